// File: doc/BRIEF.md
# Cache ECC Error Invalidation Controller

This block sits beside a two-stage instruction cache lookup. In the first stage a lookup request drives the tag and data RAMs. In the second stage the block receives the per-way hit vector and the per-way error flags from the tag and data RAM checkers. Any flagged error, whether in a tag or a data RAM and whatever its kind, turns the lookup into a miss, so the fetch logic refills from main memory in the usual way. The block also emits a one-cycle recoverable-class alert pulse.

The block keeps the lookup index and the set of ways that reported an error. On the next cycle it takes the RAM port for an invalidating write to that line, which clears the valid bit of only the recorded ways. During that cycle it stalls first-stage lookups. The erroneous data is never corrected. A parameter removes the protection entirely, and then the alert and the whole invalidation write interface are held at zero.

Top module: `ecc_inv_ctrl`

## Requirements
- R1: After a synchronous reset, `lkp_stall_o`, `inv_req_o`, `ecc_err_o`, `s2_hit_o` and `s2_miss_o` are 0, and `ram_op_o` is 0 (idle).
- R2: `s2_hit_o` is 1 only when the second stage holds a valid lookup, at least one way hits and no way reports a tag or data error. `s2_hit_ways_o` equals the raw hit vector when no error is flagged and is all zero when any error is flagged.
- R3: `s2_miss_o` is 1 exactly when the second stage holds a valid lookup and `s2_hit_o` is 0, so an error always produces a miss.
- R4: `ecc_err_o` is 1 for exactly the cycle in which a valid second-stage lookup sees any tag or data error flag. Error flags presented while the second stage is empty raise neither the alert nor a write.
- R5: In the cycle after an error, `inv_req_o` is 1, `inv_index_o` is the index of the erroring lookup and `inv_ways_o` is the bitwise OR of its tag and data error vectors. The write lasts one cycle unless a fresh error follows.
- R6: `lkp_stall_o` is 1 during every invalidation write cycle. A request presented in that cycle is not accepted, so on the next cycle the second stage reports neither a hit nor a miss.
- R7: `ram_op_o` shows the RAM port use in each cycle: 2 means an invalidation write, with `ram_index_o` equal to the recorded index; 1 means an accepted lookup, with `ram_index_o` equal to `lkp_index_i`; 0 means idle.
- R8: Errors on two lookups in consecutive cycles produce two invalidation writes in consecutive cycles, each carrying its own index and ways, and neither record is lost.
- R9: With `ECC_EN` = 0, `ecc_err_o`, `inv_req_o`, `inv_ways_o`, `inv_index_o` and `lkp_stall_o` stay 0. Error flags then have no effect, and `s2_hit_o` follows the raw hit vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lkp_req_i | input | 1 | First-stage lookup request |
| lkp_index_i | input | INDEX_W | First-stage lookup index |
| way_hit_i | input | NUM_WAYS | Second-stage raw per-way tag match |
| tag_err_i | input | NUM_WAYS | Second-stage per-way tag RAM error flags |
| data_err_i | input | NUM_WAYS | Second-stage per-way data RAM error flags |
| lkp_stall_o | output | 1 | First-stage lookups blocked this cycle |
| ram_op_o | output | 2 | RAM port use: 0 idle, 1 lookup, 2 invalidate |
| ram_index_o | output | INDEX_W | Index driven to the RAMs |
| s2_hit_o | output | 1 | Error-free hit in the second stage |
| s2_hit_ways_o | output | NUM_WAYS | Hit ways after error masking |
| s2_miss_o | output | 1 | Second-stage lookup must refill |
| inv_req_o | output | 1 | Invalidation write this cycle |
| inv_ways_o | output | NUM_WAYS | Ways whose valid bit is cleared |
| inv_index_o | output | INDEX_W | Line index being invalidated |
| ecc_err_o | output | 1 | Recoverable alert pulse |

## Verification
The main path is driven with lookups that carry a clean hit, a clean miss, a tag-only error, a data-only error, errors on both RAMs of the same way, and scattered errors across several ways. Together these separate the gating of the hit from the way set that is recorded, and show that the recorded way set is the union of the two flag vectors and not just the hit way. Directed sequences cover three further cases. The first places a request in the write cycle to show that it is dropped. The second puts errors on back-to-back lookups to show that both records survive. The third presents error flags while the second stage is empty. A second instance, built without protection, receives the same vectors, which shows that the error flags are ignored there.

// File: rtl/ecc_inv_pkg.sv
package ecc_inv_pkg;

    localparam int unsigned DEF_WAYS    = 2;
    localparam int unsigned DEF_INDEX_W = 8;

    typedef enum logic [1:0] {
        RAM_IDLE   = 2'd0,
        RAM_LOOKUP = 2'd1,
        RAM_INVAL  = 2'd2
    } ram_op_e;

endpackage

// File: rtl/ecc_inv_detect.sv
module ecc_inv_detect #(
    parameter int unsigned NUM_WAYS = 2,
    parameter bit          ECC_EN   = 1'b1
) (
    input  logic                s2_valid_i,
    input  logic [NUM_WAYS-1:0] way_hit_i,
    input  logic [NUM_WAYS-1:0] tag_err_i,
    input  logic [NUM_WAYS-1:0] data_err_i,
    output logic [NUM_WAYS-1:0] err_ways_o,
    output logic                err_any_o,
    output logic                hit_o,
    output logic [NUM_WAYS-1:0] hit_ways_o,
    output logic                miss_o
);

    logic [NUM_WAYS-1:0] err_ways;
    logic                err_seen;

    if (ECC_EN) begin : gen_ecc
        for (genvar w = 0; w < NUM_WAYS; w++) begin : gen_way
            assign err_ways[w] = tag_err_i[w] | data_err_i[w];
        end
    end else begin : gen_no_ecc
        assign err_ways = '0;
    end

    assign err_seen = |err_ways;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : gen_mask
        assign hit_ways_o[w] = way_hit_i[w] & ~err_seen;
    end

    assign err_ways_o = err_ways;
    assign err_any_o  = s2_valid_i & err_seen;
    assign hit_o      = s2_valid_i & (|hit_ways_o);
    assign miss_o     = s2_valid_i & ~hit_o;

endmodule

// File: rtl/ecc_inv_record.sv
module ecc_inv_record #(
    parameter int unsigned NUM_WAYS = 2,
    parameter int unsigned INDEX_W  = 8,
    parameter bit          ECC_EN   = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                err_any_i,
    input  logic [NUM_WAYS-1:0] err_ways_i,
    input  logic [INDEX_W-1:0]  s2_index_i,
    output logic                inv_req_o,
    output logic [NUM_WAYS-1:0] inv_ways_o,
    output logic [INDEX_W-1:0]  inv_index_o
);

    if (ECC_EN) begin : gen_rec
        logic                inv_req_q;
        logic [NUM_WAYS-1:0] inv_ways_q;
        logic [INDEX_W-1:0]  inv_index_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                inv_req_q   <= 1'b0;
                inv_ways_q  <= '0;
                inv_index_q <= '0;
            end else begin
                inv_req_q <= err_any_i;
                if (err_any_i) begin
                    inv_ways_q  <= err_ways_i;
                    inv_index_q <= s2_index_i;
                end
            end
        end

        assign inv_req_o   = inv_req_q;
        assign inv_ways_o  = inv_ways_q;
        assign inv_index_o = inv_index_q;
    end else begin : gen_no_rec
        assign inv_req_o   = 1'b0;
        assign inv_ways_o  = '0;
        assign inv_index_o = '0;
    end

endmodule

// File: rtl/ecc_inv_port.sv
module ecc_inv_port
    import ecc_inv_pkg::*;
#(
    parameter int unsigned INDEX_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               lkp_req_i,
    input  logic [INDEX_W-1:0] lkp_index_i,
    input  logic               inv_req_i,
    input  logic [INDEX_W-1:0] inv_index_i,
    output logic               s2_valid_o,
    output logic [INDEX_W-1:0] s2_index_o,
    output ram_op_e            ram_op_o,
    output logic [INDEX_W-1:0] ram_index_o
);

    logic               accept;
    logic               s2_valid_q;
    logic [INDEX_W-1:0] s2_index_q;

    assign accept = lkp_req_i & ~inv_req_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s2_valid_q <= 1'b0;
            s2_index_q <= '0;
        end else begin
            s2_valid_q <= accept;
            if (accept) begin
                s2_index_q <= lkp_index_i;
            end
        end
    end

    always_comb begin
        if (inv_req_i) begin
            ram_op_o    = RAM_INVAL;
            ram_index_o = inv_index_i;
        end else if (accept) begin
            ram_op_o    = RAM_LOOKUP;
            ram_index_o = lkp_index_i;
        end else begin
            ram_op_o    = RAM_IDLE;
            ram_index_o = lkp_index_i;
        end
    end

    assign s2_valid_o = s2_valid_q;
    assign s2_index_o = s2_index_q;

endmodule

// File: rtl/ecc_inv_ctrl.sv
module ecc_inv_ctrl
    import ecc_inv_pkg::*;
#(
    parameter int unsigned NUM_WAYS = DEF_WAYS,
    parameter int unsigned INDEX_W  = DEF_INDEX_W,
    parameter bit          ECC_EN   = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                lkp_req_i,
    input  logic [INDEX_W-1:0]  lkp_index_i,
    input  logic [NUM_WAYS-1:0] way_hit_i,
    input  logic [NUM_WAYS-1:0] tag_err_i,
    input  logic [NUM_WAYS-1:0] data_err_i,
    output logic                lkp_stall_o,
    output logic [1:0]          ram_op_o,
    output logic [INDEX_W-1:0]  ram_index_o,
    output logic                s2_hit_o,
    output logic [NUM_WAYS-1:0] s2_hit_ways_o,
    output logic                s2_miss_o,
    output logic                inv_req_o,
    output logic [NUM_WAYS-1:0] inv_ways_o,
    output logic [INDEX_W-1:0]  inv_index_o,
    output logic                ecc_err_o
);

    logic                s2_valid;
    logic [INDEX_W-1:0]  s2_index;
    logic [NUM_WAYS-1:0] err_ways;
    logic                err_any;
    logic                inv_req;
    logic [NUM_WAYS-1:0] inv_ways;
    logic [INDEX_W-1:0]  inv_index;
    ram_op_e             ram_op;

    ecc_inv_port #(
        .INDEX_W (INDEX_W)
    ) u_port (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .lkp_req_i   (lkp_req_i),
        .lkp_index_i (lkp_index_i),
        .inv_req_i   (inv_req),
        .inv_index_i (inv_index),
        .s2_valid_o  (s2_valid),
        .s2_index_o  (s2_index),
        .ram_op_o    (ram_op),
        .ram_index_o (ram_index_o)
    );

    ecc_inv_detect #(
        .NUM_WAYS (NUM_WAYS),
        .ECC_EN   (ECC_EN)
    ) u_detect (
        .s2_valid_i (s2_valid),
        .way_hit_i  (way_hit_i),
        .tag_err_i  (tag_err_i),
        .data_err_i (data_err_i),
        .err_ways_o (err_ways),
        .err_any_o  (err_any),
        .hit_o      (s2_hit_o),
        .hit_ways_o (s2_hit_ways_o),
        .miss_o     (s2_miss_o)
    );

    ecc_inv_record #(
        .NUM_WAYS (NUM_WAYS),
        .INDEX_W  (INDEX_W),
        .ECC_EN   (ECC_EN)
    ) u_record (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .err_any_i   (err_any),
        .err_ways_i  (err_ways),
        .s2_index_i  (s2_index),
        .inv_req_o   (inv_req),
        .inv_ways_o  (inv_ways),
        .inv_index_o (inv_index)
    );

    assign lkp_stall_o = inv_req;
    assign ram_op_o    = ram_op;
    assign inv_req_o   = inv_req;
    assign inv_ways_o  = inv_ways;
    assign inv_index_o = inv_index;
    assign ecc_err_o   = err_any;

    AST_NO_HIT_ON_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        ecc_err_o |-> !s2_hit_o && (s2_hit_ways_o == '0)); // R2

    AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(s2_hit_o && s2_miss_o)); // R3

    AST_ERR_LEADS_INV: assert property (@(posedge clk_i) disable iff (rst_i)
        ecc_err_o |=> inv_req_o); // R5

    AST_INV_WAYS_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        inv_req_o |-> (inv_ways_o != '0)); // R5

    AST_STALL_IN_INV: assert property (@(posedge clk_i) disable iff (rst_i)
        inv_req_o |-> lkp_stall_o && (ram_op_o == 2'd2)); // R6

    AST_STALL_DROPS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        lkp_stall_o |=> !s2_hit_o && !s2_miss_o); // R6

endmodule

// File: tb/ecc_inv_ctrl_test.sv
module ecc_inv_ctrl_test;

    localparam int W  = 4;
    localparam int IW = 6;

    // vector: [17:12] index, [11:8] way hit, [7:4] tag err, [3:0] data err
    localparam logic [17:0] VEC [0:7] = '{
        {6'h05, 4'b0001, 4'b0000, 4'b0000},
        {6'h0A, 4'b0000, 4'b0000, 4'b0000},
        {6'h11, 4'b0010, 4'b0010, 4'b0000},
        {6'h3F, 4'b0100, 4'b0000, 4'b1000},
        {6'h00, 4'b1000, 4'b0001, 4'b0001},
        {6'h2A, 4'b0000, 4'b1100, 4'b0011},
        {6'h15, 4'b0100, 4'b0000, 4'b0000},
        {6'h20, 4'b0000, 4'b0000, 4'b0100}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [IW-1:0] idx = '0;
    logic [W-1:0]  hit = '0;
    logic [W-1:0]  terr = '0;
    logic [W-1:0]  derr = '0;

    logic          stall, s2h, s2m, invr, eerr;
    logic [1:0]    rop;
    logic [IW-1:0] ridx, iidx;
    logic [W-1:0]  hways, iways;

    logic          o_stall, o_s2h, o_s2m, o_invr, o_eerr;
    logic [1:0]    o_rop;
    logic [IW-1:0] o_ridx, o_iidx;
    logic [W-1:0]  o_hways, o_iways;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ecc_inv_ctrl #(.NUM_WAYS(W), .INDEX_W(IW), .ECC_EN(1'b1)) uut (
        .clk_i(clk), .rst_i(rst), .lkp_req_i(req), .lkp_index_i(idx),
        .way_hit_i(hit), .tag_err_i(terr), .data_err_i(derr),
        .lkp_stall_o(stall), .ram_op_o(rop), .ram_index_o(ridx),
        .s2_hit_o(s2h), .s2_hit_ways_o(hways), .s2_miss_o(s2m),
        .inv_req_o(invr), .inv_ways_o(iways), .inv_index_o(iidx),
        .ecc_err_o(eerr)
    );

    ecc_inv_ctrl #(.NUM_WAYS(W), .INDEX_W(IW), .ECC_EN(1'b0)) uut_off (
        .clk_i(clk), .rst_i(rst), .lkp_req_i(req), .lkp_index_i(idx),
        .way_hit_i(hit), .tag_err_i(terr), .data_err_i(derr),
        .lkp_stall_o(o_stall), .ram_op_o(o_rop), .ram_index_o(o_ridx),
        .s2_hit_o(o_s2h), .s2_hit_ways_o(o_hways), .s2_miss_o(o_s2m),
        .inv_req_o(o_invr), .inv_ways_o(o_iways), .inv_index_o(o_iidx),
        .ecc_err_o(o_eerr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        #1;
        check("R1 stall", 32'(stall), 0);
        check("R1 inv_req", 32'(invr), 0);
        check("R1 ecc_err", 32'(eerr), 0);
        check("R1 hit", 32'(s2h), 0);
        check("R1 miss", 32'(s2m), 0);
        check("R1 ram_op", 32'(rop), 0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            logic [IW-1:0] v_idx;
            logic [W-1:0]  v_hit, v_terr, v_derr, v_err;
            logic          any;
            v_idx  = VEC[i][17:12];
            v_hit  = VEC[i][11:8];
            v_terr = VEC[i][7:4];
            v_derr = VEC[i][3:0];
            v_err  = v_terr | v_derr;
            any    = |v_err;

            step();
            req = 1'b1; idx = v_idx; hit = '0; terr = '0; derr = '0;
            #1;
            check("R7 lookup op", 32'(rop), 1);
            check("R7 lookup index", 32'(ridx), 32'(v_idx));
            check("R5 write is one cycle", 32'(invr), 0);

            step();
            req = 1'b0; hit = v_hit; terr = v_terr; derr = v_derr;
            #1;
            check("R2 hit", 32'(s2h), 32'((|v_hit) && !any));
            check("R2 hit ways", 32'(hways), any ? 32'd0 : 32'(v_hit));
            check("R3 miss", 32'(s2m), 32'(!((|v_hit) && !any)));
            check("R4 alert", 32'(eerr), 32'(any));
            check("R9 off alert", 32'(o_eerr), 0);
            check("R9 off hit", 32'(o_s2h), 32'(|v_hit));

            step();
            hit = '0; terr = '0; derr = '0;
            #1;
            check("R5 inv_req", 32'(invr), 32'(any));
            check("R6 stall", 32'(stall), 32'(any));
            check("R7 op", 32'(rop), any ? 32'd2 : 32'd0);
            check("R4 alert drops", 32'(eerr), 0);
            if (any) begin
                check("R5 inv_index", 32'(iidx), 32'(v_idx));
                check("R5 inv_ways", 32'(iways), 32'(v_err));
                check("R7 write index", 32'(ridx), 32'(v_idx));
            end
            check("R9 off inv_req", 32'(o_invr), 0);
            check("R9 off stall", 32'(o_stall), 0);
            check("R9 off ways", 32'(o_iways), 0);
            check("R9 off index", 32'(o_iidx), 0);
        end

        // R6: request during the write cycle is dropped
        step();
        req = 1'b1; idx = 6'h07;
        step();
        req = 1'b0; hit = 4'b0001; terr = 4'b0001;
        step();
        terr = '0; req = 1'b1; idx = 6'h09;
        #1;
        check("R6 stall in write", 32'(stall), 1);
        check("R7 write op", 32'(rop), 2);
        check("R7 write index", 32'(ridx), 32'h07);
        step();
        req = 1'b0;
        #1;
        check("R6 dropped no hit", 32'(s2h), 0);
        check("R6 dropped no miss", 32'(s2m), 0);
        check("R6 stall released", 32'(stall), 0);
        hit = '0;

        // R8: back-to-back errors
        step();
        req = 1'b1; idx = 6'h0C;
        step();
        idx = 6'h1B; hit = 4'b0010; terr = 4'b0010;
        #1;
        check("R8 lookup in error cycle", 32'(rop), 1);
        check("R8 first alert", 32'(eerr), 1);
        step();
        req = 1'b0; hit = '0; terr = '0; derr = 4'b0100;
        #1;
        check("R8 first write", 32'(invr), 1);
        check("R8 first index", 32'(iidx), 32'h0C);
        check("R8 first ways", 32'(iways), 32'b0010);
        check("R8 second alert", 32'(eerr), 1);
        step();
        derr = '0;
        #1;
        check("R8 second write", 32'(invr), 1);
        check("R8 second index", 32'(iidx), 32'h1B);
        check("R8 second ways", 32'(iways), 32'b0100);
        step();
        #1;
        check("R8 writes end", 32'(invr), 0);

        // R4: error flags with an empty second stage
        terr = 4'b1111; derr = 4'b1111;
        #1;
        check("R4 empty stage alert", 32'(eerr), 0);
        check("R4 empty stage miss", 32'(s2m), 0);
        step();
        terr = '0; derr = '0;
        #1;
        check("R4 empty stage no write", 32'(invr), 0);

        step();
        finish_run();
    end

endmodule